// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block links a host-side data port to an on-board packet buffer RAM and carries out programmed remote DMA. The host first loads a current byte address, a remaining byte count, and the lower and upper ring bounds as page numbers. It then issues byte, 16-bit or 32-bit accesses through a single data port. Every accepted access moves the address forward and the count back by the access size. When the address lands on the upper ring bound, it is reloaded from the lower bound. When the count becomes zero, a completion flag is latched in a small interrupt status register.

The buffer holds two backed regions: a small low region starting at address zero, and a packet region delimited by parameters. Multi-byte data is little-endian. Reads from an address outside both regions return all ones for the width of the access. Writes to such an address are dropped, but the address and count still advance.

Top module: `rdma_engine`

## Requirements
- R1: After reset, the current address, the count, the status register and the read data are all zero, and `irq` is low.
- R2: A `cfg_we` pulse loads the register chosen by `cfg_sel` (0 current address, 1 count, 2 lower ring page, 3 upper ring page; a page value p stands for byte address p*256). Any data-port request in the same cycle is ignored completely.
- R3: `dp_size` encodes 0 byte, 1 16-bit and 2 or 3 32-bit. A 16-bit access clears address bit 0 before it reaches memory, and a 32-bit access clears bits 1:0.
- R4: Memory is backed only at aligned addresses below `LOW_SIZE` and from `PMEM_START` up to `MEM_SIZE`-1. Writes to other addresses change no stored byte.
- R5: A read outside the backed regions returns 0xFF for a byte access, 0x0000FFFF for a 16-bit access and 0xFFFFFFFF for a 32-bit access.
- R6: Data is little-endian: the lowest address holds bits 7:0. Byte and 16-bit reads return their data zero-extended in the low bits of `dp_rdata`.
- R7: Each accepted access adds 1, 2 or 4 to the unaligned current address (modulo 2^16) and subtracts the same amount from the count (modulo 2^16).
- R8: If the advanced address equals the upper ring bound, the current address becomes the lower ring bound instead.
- R9: A write while the count is zero is ignored completely: no memory change, no address or count change, no status change.
- R10: A read while the count is zero still transfers data and advances, so the count wraps (0 becomes 0xFFFC for a 32-bit read).
- R11: When an access leaves the count at zero, status bit 6 (`RDC_BIT`) is set.
- R12: Writing `isr_wdata` with `isr_wr` clears every status bit that has a 1 in `isr_wdata`. A completion in the same cycle wins over a clear of its bit.
- R13: `irq` is high exactly when some status bit and the same bit of `imr` are both 1.
- R14: `dp_rdata` changes only on an accepted read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the pointer registers |
| cfg_sel | input | 2 | Register select for the load |
| cfg_data | input | 16 | Load value (page in bits 7:0 for ring bounds) |
| dp_req | input | 1 | Data-port access request |
| dp_we | input | 1 | 1 write, 0 read |
| dp_size | input | 2 | Access width code |
| dp_wdata | input | 32 | Write data, low bits used for narrow accesses |
| dp_rdata | output | 32 | Read data, registered |
| isr_wr | input | 1 | Status write-one-to-clear strobe |
| isr_wdata | input | 8 | Bits to clear |
| imr | input | 8 | Interrupt mask |
| isr_o | output | 8 | Interrupt status register |
| irq | output | 1 | Interrupt request |
| cur_addr_o | output | 16 | Current DMA byte address |
| cur_cnt_o | output | 16 | Remaining byte count |

## Verification
Pointer loads, address and count advances, and status updates all show on the outputs right after the one rising edge that samples the request. `dp_rdata` is registered at that same edge, so read data is due one cycle after the request. `irq` follows the status register and the mask within the same cycle, with no extra register. The bench drives every request at a falling edge, removes it at the next falling edge, and samples there, which falls after exactly one rising edge. For mask changes it waits a short delay before sampling `irq`.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2,
      ACC_WIDE = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      SEL_ADDR    = 2'd0,
      SEL_COUNT   = 2'd1,
      SEL_RING_LO = 2'd2,
      SEL_RING_HI = 2'd3
   } cfg_sel_e;

   // bytes moved by one access of the given width code
   function automatic logic [2:0] step_of(input logic [1:0] sz);
      case (sz)
         ACC_BYTE: step_of = 3'd1;
         ACC_HALF: step_of = 3'd2;
         default:  step_of = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/rdma_window.sv
module rdma_window
   import rdma_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LOW_SIZE   = 32,
   parameter int PMEM_START = 16384,
   parameter int MEM_SIZE   = 32768,
   parameter int ROW_W      = 13
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] aligned,
   output logic              hit,
   output logic [ROW_W-1:0]  row,
   output logic [3:0]        lanes
);
   localparam logic [ADDR_W:0]   LOW_LIM  = LOW_SIZE[ADDR_W:0];
   localparam logic [ADDR_W:0]   PKT_LO   = PMEM_START[ADDR_W:0];
   localparam logic [ADDR_W:0]   PKT_HI   = MEM_SIZE[ADDR_W:0];
   localparam logic [ADDR_W-1:0] PKT_BASE = PMEM_START[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] LOW_ROWS = ADDR_W'(LOW_SIZE / 4);

   logic in_low, in_pkt;

   always_comb begin
      aligned = addr;
      case (size)
         ACC_BYTE: ;
         ACC_HALF: aligned[0] = 1'b0;
         default:  aligned[1:0] = 2'b00;
      endcase
      in_low = {1'b0, aligned} < LOW_LIM;
      in_pkt = ({1'b0, aligned} >= PKT_LO) && ({1'b0, aligned} < PKT_HI);
      hit    = in_low || in_pkt;
      if (in_low) row = ROW_W'(aligned >> 2);
      else        row = ROW_W'(((aligned - PKT_BASE) >> 2) + LOW_ROWS);
      case (size)
         ACC_BYTE: lanes = 4'b0001 << aligned[1:0];
         ACC_HALF: lanes = aligned[1] ? 4'b1100 : 4'b0011;
         default:  lanes = 4'b1111;
      endcase
   end
endmodule

// File: rtl/rdma_bufram.sv
module rdma_bufram #(
   parameter int ROWS  = 4104,
   parameter int ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             re,
   input  logic [3:0]       lanes,
   input  logic [ROW_W-1:0] row,
   input  logic [31:0]      wdata,
   output logic [31:0]      q
);
   for (genvar l = 0; l < 4; l++) begin : g_lane
      logic [7:0] mem [ROWS];

      always_ff @(posedge clk) begin
         if (we && lanes[l]) mem[row] <= wdata[8*l +: 8];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)  q[8*l +: 8] <= 8'h00;
         else if (re) q[8*l +: 8] <= mem[row];
      end
   end
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr
   import rdma_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter int PAGE_SHIFT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic              go,
   input  logic [2:0]        step,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              done_o
);
   localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

   logic [ADDR_W-1:0] addr_q, addr_inc, addr_nxt, ring_lo, ring_hi;
   logic [CNT_W-1:0]  cnt_q, cnt_dec;
   logic [PAGE_W-1:0] lo_pg_q, hi_pg_q;

   always_comb begin
      ring_lo  = {lo_pg_q, {PAGE_SHIFT{1'b0}}};
      ring_hi  = {hi_pg_q, {PAGE_SHIFT{1'b0}}};
      addr_inc = addr_q + ADDR_W'(step);
      cnt_dec  = cnt_q - CNT_W'(step);
      addr_nxt = (addr_inc == ring_hi) ? ring_lo : addr_inc;
      done_o   = go && (cnt_dec == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cnt_q   <= '0;
         lo_pg_q <= '0;
         hi_pg_q <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_ADDR:    addr_q  <= cfg_data;
            SEL_COUNT:   cnt_q   <= CNT_W'(cfg_data);
            SEL_RING_LO: lo_pg_q <= cfg_data[PAGE_W-1:0];
            default:     hi_pg_q <= cfg_data[PAGE_W-1:0];
         endcase
      end else if (go) begin
         addr_q <= addr_nxt;
         cnt_q  <= cnt_dec;
      end
   end

   assign addr_o = addr_q;
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
   import rdma_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter int PAGE_SHIFT = 8,
   parameter int LOW_SIZE   = 32,
   parameter int PMEM_START = 16384,
   parameter int MEM_SIZE   = 32768,
   parameter int ISR_W      = 8,
   parameter int RDC_BIT    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic              dp_req,
   input  logic              dp_we,
   input  logic [1:0]        dp_size,
   input  logic [31:0]       dp_wdata,
   output logic [31:0]       dp_rdata,
   input  logic              isr_wr,
   input  logic [ISR_W-1:0]  isr_wdata,
   input  logic [ISR_W-1:0]  imr,
   output logic [ISR_W-1:0]  isr_o,
   output logic              irq,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic [CNT_W-1:0]  cur_cnt_o
);
   localparam int ROWS  = LOW_SIZE / 4 + (MEM_SIZE - PMEM_START) / 4;
   localparam int ROW_W = $clog2(ROWS);

   // elaboration-time parameter checks
   if (ADDR_W <= PAGE_SHIFT)           begin : g_chk_page  $error("ADDR_W must exceed PAGE_SHIFT"); end
   if (CNT_W > ADDR_W)                 begin : g_chk_cnt   $error("CNT_W must not exceed ADDR_W"); end
   if (LOW_SIZE % 4 != 0 || PMEM_START % 4 != 0 || MEM_SIZE % 4 != 0)
                                       begin : g_chk_align $error("regions must be word aligned"); end
   if (PMEM_START < LOW_SIZE || MEM_SIZE <= PMEM_START)
                                       begin : g_chk_order $error("region bounds out of order"); end
   if (MEM_SIZE > (1 << ADDR_W))       begin : g_chk_span  $error("MEM_SIZE exceeds address space"); end
   if (RDC_BIT >= ISR_W)               begin : g_chk_bit   $error("RDC_BIT outside status register"); end

   logic [ADDR_W-1:0] aligned;
   logic              hit, go, done;
   logic [ROW_W-1:0]  row;
   logic [3:0]        lanes;
   logic [31:0]       wr_lanes, ram_q, shifted;
   logic [1:0]        rd_off, rd_size;
   logic              rd_hit;
   logic [ISR_W-1:0]  isr_q, clr_mask, set_mask;

   rdma_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_SHIFT(PAGE_SHIFT)) u_ptr (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .go(go), .step(step_of(dp_size)), .addr_o(cur_addr_o), .cnt_o(cur_cnt_o), .done_o(done)
   );

   rdma_window #(.ADDR_W(ADDR_W), .LOW_SIZE(LOW_SIZE), .PMEM_START(PMEM_START),
                 .MEM_SIZE(MEM_SIZE), .ROW_W(ROW_W)) u_win (
      .addr(cur_addr_o), .size(dp_size), .aligned(aligned), .hit(hit), .row(row), .lanes(lanes)
   );

   rdma_bufram #(.ROWS(ROWS), .ROW_W(ROW_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(go && dp_we && hit), .re(go && !dp_we),
      .lanes(lanes), .row(row), .wdata(wr_lanes), .q(ram_q)
   );

   // writes are refused only when nothing is left to move; reads always run
   assign go = dp_req && !cfg_we && !(dp_we && (cur_cnt_o == '0));

   always_comb begin
      case (dp_size)
         ACC_BYTE: wr_lanes = {4{dp_wdata[7:0]}};
         ACC_HALF: wr_lanes = {2{dp_wdata[15:0]}};
         default:  wr_lanes = dp_wdata;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_off  <= 2'b00;
         rd_size <= ACC_BYTE;
         rd_hit  <= 1'b1;
      end else if (go && !dp_we) begin
         rd_off  <= aligned[1:0];
         rd_size <= dp_size;
         rd_hit  <= hit;
      end
   end

   always_comb begin
      shifted = ram_q >> {rd_off, 3'b000};
      case (rd_size)
         ACC_BYTE: dp_rdata = {24'h0, rd_hit ? shifted[7:0]  : 8'hFF};
         ACC_HALF: dp_rdata = {16'h0, rd_hit ? shifted[15:0] : 16'hFFFF};
         default:  dp_rdata = rd_hit ? shifted : 32'hFFFF_FFFF;
      endcase
   end

   // status register: write-one-to-clear, completion set has priority
   always_comb begin
      clr_mask = isr_wr ? isr_wdata : '0;
      set_mask = '0;
      set_mask[RDC_BIT] = done;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~clr_mask) | set_mask;
   end

   assign isr_o = isr_q;
   assign irq   = |(isr_q & imr);
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk
   import rdma_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter int LOW_SIZE   = 32,
   parameter int PMEM_START = 16384,
   parameter int ISR_W      = 8,
   parameter int RDC_BIT    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              dp_req,
   input logic              dp_we,
   input logic [1:0]        dp_size,
   input logic [31:0]       dp_rdata,
   input logic              isr_wr,
   input logic [ISR_W-1:0]  isr_wdata,
   input logic [ISR_W-1:0]  imr,
   input logic [ISR_W-1:0]  isr_o,
   input logic              irq,
   input logic [ADDR_W-1:0] cur_addr_o,
   input logic [CNT_W-1:0]  cur_cnt_o
);
   localparam logic [ADDR_W:0] LOW_LIM = LOW_SIZE[ADDR_W:0];
   localparam logic [ADDR_W:0] PKT_LO  = PMEM_START[ADDR_W:0];

   logic              accepted, gap_word;
   logic [ADDR_W-1:0] word_addr;

   always_comb begin
      accepted  = dp_req && !cfg_we && !(dp_we && cur_cnt_o == '0);
      word_addr = {cur_addr_o[ADDR_W-1:2], 2'b00};
      gap_word  = ({1'b0, word_addr} >= LOW_LIM) && ({1'b0, word_addr} < PKT_LO);
   end

   // R7: a 32-bit access takes four off the count
   p_word_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accepted && dp_size[1] |=> cur_cnt_o == $past(cur_cnt_o) - CNT_W'(4));

   // R9: a write at zero count leaves pointers and completion untouched
   p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dp_req && dp_we && !cfg_we && cur_cnt_o == '0 && !isr_wr
      |=> $stable(cur_cnt_o) && $stable(cur_addr_o) && $stable(isr_o));

   // R5: a 32-bit read between the two regions returns all ones
   p_gap_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accepted && !dp_we && dp_size == ACC_WORD && gap_word |=> dp_rdata == 32'hFFFF_FFFF);

   // R11: the last bytes of a transfer raise the completion bit
   p_complete_r11: assert property (@(posedge clk) disable iff (!rst_n)
      accepted && cur_cnt_o == CNT_W'(step_of(dp_size)) |=> isr_o[RDC_BIT]);

   // R12: a clear with no access in flight removes the written bits
   p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      isr_wr && !dp_req |=> (isr_o & $past(isr_wdata)) == '0);

   // R13: a newly raised unmasked completion drives the interrupt
   p_irq_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_o[RDC_BIT]) && imr[RDC_BIT] |-> irq);

   // R14: read data holds when no read is accepted
   p_rdata_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !(accepted && !dp_we) |=> $stable(dp_rdata));
endmodule

bind rdma_engine rdma_engine_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOW_SIZE(LOW_SIZE),
   .PMEM_START(PMEM_START), .ISR_W(ISR_W), .RDC_BIT(RDC_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .dp_req(dp_req), .dp_we(dp_we),
   .dp_size(dp_size), .dp_rdata(dp_rdata), .isr_wr(isr_wr), .isr_wdata(isr_wdata),
   .imr(imr), .isr_o(isr_o), .irq(irq), .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o)
);

// File: tb/sim_rdma_engine.sv
`timescale 1ns/100ps
module sim_rdma_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_data = 16'h0;
   logic        dp_req = 1'b0, dp_we = 1'b0;
   logic [1:0]  dp_size = 2'd0;
   logic [31:0] dp_wdata = 32'h0;
   logic [31:0] dp_rdata;
   logic        isr_wr = 1'b0;
   logic [7:0]  isr_wdata = 8'h0, imr = 8'h0, isr_o;
   logic        irq;
   logic [15:0] cur_addr_o, cur_cnt_o;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   rdma_engine u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .dp_req(dp_req), .dp_we(dp_we), .dp_size(dp_size), .dp_wdata(dp_wdata),
      .dp_rdata(dp_rdata), .isr_wr(isr_wr), .isr_wdata(isr_wdata), .imr(imr),
      .isr_o(isr_o), .irq(irq), .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic acc(input logic we, input logic [1:0] sz, input logic [31:0] wd);
      @(negedge clk); dp_req = 1'b1; dp_we = we; dp_size = sz; dp_wdata = wd;
      @(negedge clk); dp_req = 1'b0; dp_we = 1'b0;
   endtask

   task automatic clear_isr();
      @(negedge clk); isr_wr = 1'b1; isr_wdata = 8'hFF;
      @(negedge clk); isr_wr = 1'b0; isr_wdata = 8'h00;
   endtask

   task automatic point(input logic [15:0] a, input logic [15:0] c);
      cfg(2'd0, a); cfg(2'd1, c);
   endtask

   task automatic t_reset();
      chk("R1 addr", 32'(cur_addr_o), 32'h0);
      chk("R1 count", 32'(cur_cnt_o), 32'h0);
      chk("R1 isr", 32'(isr_o), 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 rdata", dp_rdata, 32'h0);
   endtask

   task automatic t_word_fill();
      point(16'h4000, 16'd8); cfg(2'd2, 16'h0040); cfg(2'd3, 16'h0080);
      chk("R2 addr load", 32'(cur_addr_o), 32'h4000);
      chk("R2 count load", 32'(cur_cnt_o), 32'd8);
      acc(1'b1, 2'd2, 32'h1122_3344);
      chk("R7 addr +4", 32'(cur_addr_o), 32'h4004);
      chk("R7 count -4", 32'(cur_cnt_o), 32'd4);
      chk("R11 not yet", 32'(isr_o), 32'h0);
      acc(1'b1, 2'd2, 32'hAABB_CCDD);
      chk("R11 complete", 32'(isr_o), 32'h40);
      chk("R13 masked", 32'(irq), 32'h0);
      imr = 8'h40; #1;
      chk("R13 unmasked", 32'(irq), 32'h1);
      imr = 8'h01; #1;
      chk("R13 other bit", 32'(irq), 32'h0);
      imr = 8'h40;
      clear_isr();
      chk("R12 w1c", 32'(isr_o), 32'h0);
      chk("R13 after clear", 32'(irq), 32'h0);
   endtask

   task automatic t_lanes();
      point(16'h4000, 16'd8);
      acc(1'b0, 2'd0, 0);
      chk("R6 byte 0", dp_rdata, 32'h44);
      chk("R7 addr +1", 32'(cur_addr_o), 32'h4001);
      acc(1'b0, 2'd1, 0);
      chk("R3 half aligned", dp_rdata, 32'h3344);
      chk("R7 addr +2 unaligned", 32'(cur_addr_o), 32'h4003);
      acc(1'b0, 2'd2, 0);
      chk("R3 word aligned", dp_rdata, 32'h1122_3344);
      chk("R7 count 1", 32'(cur_cnt_o), 32'd1);
      acc(1'b0, 2'd0, 0);
      chk("R6 byte 7", dp_rdata, 32'hAA);
      chk("R11 byte done", 32'(isr_o), 32'h40);
      clear_isr();
      point(16'h4006, 16'd2);
      acc(1'b0, 2'd1, 0);
      chk("R6 upper half", dp_rdata, 32'hAABB);
      point(16'h4005, 16'd1);
      acc(1'b1, 2'd0, 32'hFFFF_FF5A);
      point(16'h4004, 16'd4);
      acc(1'b0, 2'd3, 0);
      chk("R6 byte merge", dp_rdata, 32'hAABB_5ADD);
      clear_isr();
   endtask

   task automatic t_zero_write();
      point(16'h4000, 16'd0);
      acc(1'b1, 2'd2, 32'hDEAD_BEEF);
      chk("R9 addr held", 32'(cur_addr_o), 32'h4000);
      chk("R9 count held", 32'(cur_cnt_o), 32'h0);
      chk("R9 no flag", 32'(isr_o), 32'h0);
      cfg(2'd1, 16'd4);
      acc(1'b0, 2'd2, 0);
      chk("R9 memory kept", dp_rdata, 32'h1122_3344);
      clear_isr();
   endtask

   task automatic t_read_zero();
      point(16'h4000, 16'd0);
      acc(1'b0, 2'd2, 0);
      chk("R10 data", dp_rdata, 32'h1122_3344);
      chk("R10 count wraps", 32'(cur_cnt_o), 32'hFFFC);
      chk("R10 addr", 32'(cur_addr_o), 32'h4004);
      chk("R10 no flag", 32'(isr_o), 32'h0);
   endtask

   task automatic t_wrap();
      cfg(2'd2, 16'h0040); cfg(2'd3, 16'h0041);
      point(16'h40FC, 16'd16);
      acc(1'b1, 2'd2, 32'h0102_0304);
      chk("R8 word wrap", 32'(cur_addr_o), 32'h4000);
      chk("R8 count", 32'(cur_cnt_o), 32'd12);
      cfg(2'd0, 16'h40FE);
      acc(1'b1, 2'd1, 32'h0000_BEEF);
      chk("R8 half wrap", 32'(cur_addr_o), 32'h4000);
      cfg(2'd0, 16'h40FC);
      acc(1'b0, 2'd2, 0);
      chk("R8 data at edge", dp_rdata, 32'hBEEF_0304);
      chk("R8 read wrap", 32'(cur_addr_o), 32'h4000);
      cfg(2'd3, 16'h0080);
   endtask

   task automatic t_window();
      point(16'h0010, 16'h0100);
      acc(1'b1, 2'd2, 32'hCAFE_F00D);
      cfg(2'd0, 16'h0110);
      acc(1'b1, 2'd2, 32'h1234_5678);
      chk("R7 advance outside", 32'(cur_addr_o), 32'h0114);
      cfg(2'd0, 16'h0110);
      acc(1'b0, 2'd2, 0);
      chk("R5 word ones", dp_rdata, 32'hFFFF_FFFF);
      acc(1'b0, 2'd1, 0);
      chk("R5 half ones", dp_rdata, 32'h0000_FFFF);
      acc(1'b0, 2'd0, 0);
      chk("R5 byte ones", dp_rdata, 32'h0000_00FF);
      cfg(2'd0, 16'h0010);
      acc(1'b0, 2'd2, 0);
      chk("R4 low region", dp_rdata, 32'hCAFE_F00D);
      cfg(2'd0, 16'h0020);
      acc(1'b0, 2'd2, 0);
      chk("R5 just above low", dp_rdata, 32'hFFFF_FFFF);
      cfg(2'd0, 16'h3FFC);
      acc(1'b1, 2'd2, 32'h7777_7777);
      acc(1'b0, 2'd2, 0);
      chk("R4 first packet word", dp_rdata, 32'h1122_3344);
      cfg(2'd0, 16'h3FFC);
      acc(1'b0, 2'd2, 0);
      chk("R5 just below packet", dp_rdata, 32'hFFFF_FFFF);
      cfg(2'd0, 16'h7FFC);
      acc(1'b1, 2'd2, 32'h0BAD_CAFE);
      cfg(2'd0, 16'h7FFC);
      acc(1'b0, 2'd2, 0);
      chk("R4 top word", dp_rdata, 32'h0BAD_CAFE);
      cfg(2'd0, 16'h8000);
      acc(1'b0, 2'd2, 0);
      chk("R5 past top", dp_rdata, 32'hFFFF_FFFF);
   endtask

   task automatic t_cfg_priority();
      point(16'h4000, 16'd8);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd1; cfg_data = 16'h0020;
      dp_req = 1'b1; dp_we = 1'b1; dp_size = 2'd2; dp_wdata = 32'h5555_5555;
      @(negedge clk);
      cfg_we = 1'b0; dp_req = 1'b0; dp_we = 1'b0;
      chk("R2 load wins", 32'(cur_cnt_o), 32'h20);
      chk("R2 addr unmoved", 32'(cur_addr_o), 32'h4000);
      acc(1'b0, 2'd2, 0);
      chk("R2 write dropped", dp_rdata, 32'h1122_3344);
   endtask

   task automatic t_set_wins();
      clear_isr();
      point(16'h4000, 16'd1);
      @(negedge clk);
      dp_req = 1'b1; dp_we = 1'b0; dp_size = 2'd0; isr_wr = 1'b1; isr_wdata = 8'hFF;
      @(negedge clk);
      dp_req = 1'b0; isr_wr = 1'b0; isr_wdata = 8'h00;
      chk("R12 set beats clear", 32'(isr_o), 32'h40);
      clear_isr();
      chk("R12 cleared", 32'(isr_o), 32'h0);
   endtask

   task automatic t_rdata_hold();
      point(16'h4000, 16'd4);
      acc(1'b0, 2'd2, 0);
      chk("R14 read", dp_rdata, 32'h1122_3344);
      point(16'h4004, 16'd8);
      acc(1'b1, 2'd2, 32'h6666_6666);
      chk("R14 held over write", dp_rdata, 32'h1122_3344);
      repeat (3) @(negedge clk);
      chk("R14 held idle", dp_rdata, 32'h1122_3344);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_word_fill();
      t_lanes();
      t_zero_write();
      t_read_zero();
      t_wrap();
      t_window();
      t_cfg_priority();
      t_set_wins();
      t_rdata_hold();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule